// File: doc/BRIEF.md
# Windowed Register Access Sequencer

This block sits on the initiator side of a link whose target exposes only a 1 MB register aperture into a 32 MB register space. Upstream logic issues 32-bit reads and writes that carry a full 25-bit target offset. The sequencer turns each request into the one to three register-bus transactions that reach that offset.

The lower half of the aperture maps target offsets directly. The upper half is a movable window whose position comes from a window-select register in the target. When an offset needs the window, the sequencer decides whether the window must move. If it must, the sequencer programs the select register and reads it back to confirm the value. It then performs the data access. The whole sequence is indivisible, because no new request is accepted until the response has been returned.

The last programmed window position is kept locally, so back-to-back accesses in the same window region cost a single bus transaction. A build-time parameter can disable this cache, and the window is then written on every windowed access. A readback mismatch raises a sticky error flag that a dedicated input clears.

Top module: `regwin_seq`

## Requirements
- R1: After reset, req_ready is 1 and bus_req, rsp_valid and err_flag are 0.
- R2: A request whose offset is below 0x80000, or any request while win_en is 0, produces exactly one bus transaction at the unchanged offset, with the request's direction and write data.
- R3: Otherwise the window index is offset bits [24:19], and the data transaction goes to bus address 0x80000 OR offset bits [18:0].
- R4: A window change first writes bus address 0x310C with the value (1 << 30) OR window index.
- R5: Each window write is followed at once by a read of 0x310C. err_flag is set if the returned data differs from the value written, and is left unchanged if it matches.
- R6: With the cache enabled (NO_CACHE = 0), a windowed request whose index equals the last programmed index issues only the data transaction.
- R7: The cached index is invalid after reset, so the first windowed request always programs the window, whatever its index.
- R8: req_ready is 0 from the cycle after a request is accepted until its response has been given, and it is 0 whenever bus_req is 1, so no transaction of another request can interleave.
- R9: Each accepted request yields exactly one single-cycle rsp_valid pulse, in the cycle after its data transaction is acknowledged. For reads, rsp_rdata then carries the data returned by that transaction.
- R10: err_flag stays set until err_clr is 1 at a clock edge. If a mismatch and err_clr occur in the same cycle, the flag is set.
- R11: bus_req, once raised, stays 1 with a stable bus_addr until bus_ack is 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Enables window translation for offsets at or above 0x80000 |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Sequencer idle; the request is taken when both valid and ready are 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Full target offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data of the completed read |
| bus_req | output | 1 | Register-bus transaction request |
| bus_we | output | 1 | Register-bus direction, 1 = write |
| bus_addr | output | 25 | Register-bus address |
| bus_wdata | output | 32 | Register-bus write data |
| bus_ack | input | 1 | Register-bus completion, one cycle |
| bus_rdata | input | 32 | Register-bus read data, valid with bus_ack |
| err_clr | input | 1 | Clears the window readback error flag |
| err_flag | output | 1 | Sticky window readback mismatch |

## Verification
A request accepted at a clock edge drives bus_req in the next cycle. Each bus transaction completes at the edge where the target's acknowledge is sampled. The rsp_valid pulse and read data follow one edge after the data acknowledge, and err_flag changes one edge after the readback acknowledge. Because the number of bus transactions per request depends on the window cache, the bench does not count fixed delays. It records every transaction at the moment its target model acknowledges it and compares it against a queue of expected transactions built by the driver. Responses are popped from a second queue whenever rsp_valid is seen at a falling edge. err_flag and req_ready are checked only after the response, or one falling edge after acceptance.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Sequencer phases: idle, window program, window confirm, data transfer
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEL_WR  = 2'd1,
    ST_SEL_CHK = 2'd2,
    ST_XFER    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate #(
  parameter int ADDR_W  = 25,
  parameter int SEG_LSB = 19,
  parameter int SEG_W   = 6
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              win_en,
  output logic              direct,
  output logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-1:0] xfer_addr
);

  localparam logic [ADDR_W-1:0] APER_BASE = ADDR_W'(1) << SEG_LSB;

  always_comb begin
    direct = !win_en || (offset < APER_BASE);
    seg    = offset[SEG_LSB +: SEG_W];
    if (direct) begin
      xfer_addr = offset;
    end else begin
      xfer_addr = APER_BASE | {{(ADDR_W-SEG_LSB){1'b0}}, offset[SEG_LSB-1:0]};
    end
  end

endmodule

// File: rtl/regwin_cache.sv
module regwin_cache #(
  parameter int SEG_W    = 6,
  parameter bit NO_CACHE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_seg,
  input  logic [SEG_W-1:0] cmp_seg,
  output logic             hit
);

  generate
    if (NO_CACHE) begin : g_nocache
      assign hit = 1'b0;
    end else begin : g_cache
      logic             valid_q;
      logic             valid_d;
      logic [SEG_W-1:0] seg_q;
      logic [SEG_W-1:0] seg_d;

      always_comb begin
        valid_d = valid_q;
        seg_d   = seg_q;
        if (load) begin
          valid_d = 1'b1;
          seg_d   = load_seg;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          seg_q   <= '0;
        end else if (load) begin
          valid_q <= valid_d;
          seg_q   <= seg_d;
        end
      end

      assign hit = valid_q && (seg_q == cmp_seg);
    end
  endgenerate

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int              ADDR_W    = 25,
  parameter int              DATA_W    = 32,
  parameter int              SEG_W     = 6,
  parameter logic [ADDR_W-1:0] WSEL_ADDR = 'h310C,
  parameter int              EN_BIT    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              direct,
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              hit,
  output logic              cache_load,
  output logic [SEG_W-1:0]  seg_held,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              err_clr,
  output logic              err_flag
);

  seq_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [SEG_W-1:0]  seg_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              err_q, err_d;
  logic              accept;
  logic              rdata_en;
  logic [DATA_W-1:0] sel_word;

  assign sel_word = (DATA_W'(1) << EN_BIT) | DATA_W'(seg_q);
  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign rdata_en = (state_q == ST_XFER) && bus_ack && !we_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept)  state_d = (direct || hit) ? ST_XFER : ST_SEL_WR;
      ST_SEL_WR:  if (bus_ack) state_d = ST_SEL_CHK;
      ST_SEL_CHK: if (bus_ack) state_d = ST_XFER;
      ST_XFER:    if (bus_ack) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if ((state_q == ST_SEL_CHK) && bus_ack && (bus_rdata != sel_word)) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
    rsp_valid_d = (state_q == ST_XFER) && bus_ack;
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      ST_SEL_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = WSEL_ADDR;
        bus_wdata = sel_word;
      end
      ST_SEL_CHK: begin
        bus_req  = 1'b1;
        bus_addr = WSEL_ADDR;
      end
      ST_XFER: begin
        bus_req   = 1'b1;
        bus_we    = we_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      err_q       <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      seg_q   <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      addr_q  <= xfer_addr;
      wdata_q <= req_wdata;
      seg_q   <= seg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata_q <= '0;
    end else if (rdata_en) begin
      rsp_rdata_q <= bus_rdata;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign cache_load = (state_q == ST_SEL_WR) && bus_ack;
  assign seg_held   = seg_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign err_flag   = err_q;

endmodule

// File: rtl/regwin_seq.sv
module regwin_seq #(
  parameter int                ADDR_W    = 25,
  parameter int                DATA_W    = 32,
  parameter int                SEG_LSB   = 19,
  parameter int                SEG_W     = 6,
  parameter logic [ADDR_W-1:0] WSEL_ADDR = 'h310C,
  parameter int                EN_BIT    = 30,
  parameter bit                NO_CACHE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              err_clr,
  output logic              err_flag
);

  logic              direct;
  logic [SEG_W-1:0]  seg;
  logic [ADDR_W-1:0] xfer_addr;
  logic              hit;
  logic              cache_load;
  logic [SEG_W-1:0]  seg_held;

  regwin_xlate #(
    .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB), .SEG_W(SEG_W)
  ) i_xlate (
    .offset(req_addr), .win_en(win_en), .direct(direct),
    .seg(seg), .xfer_addr(xfer_addr)
  );

  regwin_cache #(
    .SEG_W(SEG_W), .NO_CACHE(NO_CACHE)
  ) i_cache (
    .clk(clk), .rst_n(rst_n), .load(cache_load),
    .load_seg(seg_held), .cmp_seg(seg), .hit(hit)
  );

  regwin_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W),
    .WSEL_ADDR(WSEL_ADDR), .EN_BIT(EN_BIT)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_wdata(req_wdata), .direct(direct), .seg(seg),
    .xfer_addr(xfer_addr), .hit(hit), .cache_load(cache_load),
    .seg_held(seg_held), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .err_clr(err_clr), .err_flag(err_flag)
  );

endmodule

// File: rtl/regwin_seq_chk.sv
module regwin_seq_chk #(
  parameter int ADDR_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rsp_valid,
  input logic              err_flag,
  input logic              err_clr
);

  // R8
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  // R8
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

endmodule

bind regwin_seq regwin_seq_chk #(.ADDR_W(ADDR_W)) i_regwin_seq_chk (.*);

// File: tb/test_regwin_seq.sv
module test_regwin_seq;

  typedef struct {
    bit          we;
    logic [24:0] addr;
    logic [31:0] wdata;
    string       tag;
  } op_t;

  typedef struct {
    bit          we;
    logic [31:0] rdata;
    string       tag;
  } rsp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [24:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        err_clr = 1'b0;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        req_ready, rsp_valid, bus_req, bus_we, err_flag;
  logic [31:0] rsp_rdata, bus_wdata;
  logic [24:0] bus_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  op_t  opq[$];
  rsp_t rspq[$];

  logic [31:0] tgt_win = '0;
  bit          corrupt = 1'b0;
  bit          c_valid = 1'b0;
  logic [5:0]  c_seg = '0;
  logic [31:0] exp_win = '0;
  bit          prev_rsp = 1'b0;

  regwin_seq i_regwin_seq (
    .clk(clk), .rst_n(rst_n), .win_en(win_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .err_clr(err_clr), .err_flag(err_flag)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] tgt_data(logic [24:0] a, logic [31:0] w);
    if (a < 25'h80000) return 32'h5A00_0000 ^ {7'd0, a};
    return 32'hA500_0000 ^ ({26'd0, w[5:0]} << 20) ^ {7'd0, a};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Target model and bus monitor: acknowledge one cycle after a request
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !bus_ack) begin
        if (opq.size() == 0) begin
          check(1'b0, "R8 unexpected bus op", {7'd0, bus_addr}, 32'h0);
        end else begin
          op_t e;
          e = opq.pop_front();
          check(bus_we == e.we, {e.tag, " dir"}, {31'd0, bus_we}, {31'd0, e.we});
          check(bus_addr == e.addr, {e.tag, " addr"}, {7'd0, bus_addr}, {7'd0, e.addr});
          if (e.we) check(bus_wdata == e.wdata, {e.tag, " wdata"}, bus_wdata, e.wdata);
        end
        if (bus_addr == 25'h310C) begin
          if (bus_we) tgt_win = bus_wdata;
          bus_rdata = tgt_win ^ (corrupt ? 32'h1 : 32'h0);
        end else begin
          bus_rdata = tgt_data(bus_addr, tgt_win);
        end
        bus_ack = 1'b1;
      end else begin
        bus_ack = 1'b0;
      end
    end
  end

  // Response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (prev_rsp) check(!rsp_valid, "R9 pulse width", {31'd0, rsp_valid}, 32'h0);
      if (rsp_valid) begin
        if (rspq.size() == 0) begin
          check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
        end else begin
          rsp_t r;
          r = rspq.pop_front();
          if (!r.we) check(rsp_rdata == r.rdata, {r.tag, " rdata"}, rsp_rdata, r.rdata);
          else check(1'b1, r.tag, 32'h0, 32'h0);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_req(bit we, logic [24:0] off, logic [31:0] wd, string tag);
    bit          dir;
    logic [5:0]  sg;
    logic [24:0] da;
    rsp_t        r;
    dir = !win_en || off < 25'h80000;
    sg  = off[24:19];
    da  = dir ? off : (25'h80000 | {6'd0, off[18:0]});
    if (!dir && !(c_valid && c_seg == sg)) begin
      opq.push_back('{1'b1, 25'h310C, (32'h1 << 30) | {26'd0, sg}, {tag, " R4 window write"}});
      opq.push_back('{1'b0, 25'h310C, 32'h0, {tag, " R5 window readback"}});
      c_valid = 1'b1;
      c_seg   = sg;
      exp_win = (32'h1 << 30) | {26'd0, sg};
    end
    opq.push_back('{we, da, wd, {tag, " data access"}});
    r.we = we;
    r.rdata = tgt_data(da, exp_win);
    r.tag = tag;
    rspq.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = off;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready low after accept", {31'd0, req_ready}, 32'h0);
    while (rspq.size() != 0) @(negedge clk);
    check(opq.size() == 0, {tag, " R2 R6 op count"}, opq.size(), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'h1);
    check(bus_req == 1'b0, "R1 bus_req", {31'd0, bus_req}, 32'h0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'h0);
    check(err_flag == 1'b0, "R1 err_flag", {31'd0, err_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(1'b0, 25'h0_1234, 32'h0, "R2 direct read");
    do_req(1'b1, 25'h7_FFFC, 32'hCAFE_0001, "R2 direct write");
    do_req(1'b0, 25'h008_0000 | 25'h0_0040, 32'h0, "R7 R3 first windowed read");
    do_req(1'b0, 25'h00F_0100, 32'h0, "R6 same window read");
    do_req(1'b1, 25'h1F8_0008, 32'h1234_5678, "R3 new window write");
    do_req(1'b0, 25'h1FF_FFFC, 32'h0, "R6 same window top read");
    win_en = 1'b0;
    do_req(1'b0, 25'h123_4560, 32'h0, "R2 windowing disabled read");
    win_en = 1'b1;
    check(err_flag == 1'b0, "R5 no error on good readback", {31'd0, err_flag}, 32'h0);
    corrupt = 1'b1;
    do_req(1'b0, 25'h0A0_0010, 32'h0, "R5 corrupted readback");
    check(err_flag == 1'b1, "R5 mismatch sets flag", {31'd0, err_flag}, 32'h1);
    corrupt = 1'b0;
    do_req(1'b0, 25'h0A0_0020, 32'h0, "R10 R6 after error");
    check(err_flag == 1'b1, "R10 flag sticky", {31'd0, err_flag}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_flag == 1'b0, "R10 flag cleared", {31'd0, err_flag}, 32'h0);
    do_req(1'b1, 25'h0C0_0004, 32'hBEEF_0002, "R5 good readback after clear");
    check(err_flag == 1'b0, "R5 flag stays clear", {31'd0, err_flag}, 32'h0);
    repeat (3) @(negedge clk);
    check(bus_req == 1'b0 && req_ready == 1'b1, "R8 idle at end",
          {30'd0, bus_req, req_ready}, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule